// File: doc/BRIEF.md
# Interrupt and Halt Sequencer

This block decides, at each instruction boundary of a small processor core, what the core does next. It can keep fetching, stay halted, or take an interrupt. It owns two pieces of state: the master interrupt enable and the halted flag.

Peripherals drive a vector of pending requests into the block. The core reports each retired instruction with a boundary strobe. Alongside that strobe it raises one qualifier for enable, disable, halt or return-from-interrupt instructions.

When the block decides to take an interrupt, it does three things:
- it pulses a service strobe that tells the datapath to push the program counter;
- it presents the vector address to load;
- it acknowledges the one request it chose, so the peripheral drops only that pending bit.

A halt stops the core until any request appears, and waking costs a fixed number of stall cycles. A halt issued with interrupts disabled while a request is already pending does not stop the core. Instead the block signals that the byte at the current program counter must be executed again.

Top module: `intr_halt_ctrl`

## Requirements
- R1: After reset the master enable and the halted flag are clear, so `status` reads 0x00 and `run` is high. Status encoding: bit 0 is the master enable, bit 7 is the halted flag, and all other bits are zero.
- R2: With the master enable clear, a boundary with requests pending produces no service strobe.
- R3: With the master enable set, a boundary with a request pending and no qualifier produces a one-cycle `take_irq` pulse in the cycle after the boundary. In that same cycle the master enable already reads clear.
- R4: The serviced source is the lowest-numbered pending request. `irq_vec` is 0x40 + 8 × index, and `irq_ack` is one-hot on that index only. Other pending requests remain pending and are serviced later.
- R5: A boundary carrying the enable qualifier sets the master enable but does not service at that boundary. The next boundary, after one more instruction, does service.
- R6: A boundary carrying the disable qualifier clears the master enable and does not service, even if enable was set and a request is pending.
- R7: A boundary carrying the return-from-interrupt qualifier behaves like the enable qualifier: enable is set and servicing is deferred by one instruction.
- R8: A halt with no request pending sets status bit 7 and drives `run` low. While halted, further boundary strobes and their qualifiers are ignored.
- R9: While halted, any pending request ends the halt even with the master enable clear. `run` then stays low for exactly 4 wake cycles, and nothing is serviced while enable is clear.
- R10: If the master enable is set when a halt wakes, the pending request is serviced at the end of the 4-cycle wake window. The strobe appears in the same cycle `run` returns high.
- R11: A halt issued with the master enable clear and a request pending does not halt. Instead `repeat_byte` pulses in the cycle after that boundary, and `run` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction retired this cycle |
| op_ei | input | 1 | Retired instruction was enable-interrupts |
| op_di | input | 1 | Retired instruction was disable-interrupts |
| op_halt | input | 1 | Retired instruction was halt |
| op_reti | input | 1 | Retired instruction was return-from-interrupt |
| req | input | N_SRC | Pending interrupt requests, bit 0 highest priority |
| run | output | 1 | Core may fetch and execute |
| take_irq | output | 1 | Push PC and load `irq_vec` this cycle |
| irq_vec | output | VEC_W | Vector address of the serviced source |
| irq_ack | output | N_SRC | One-hot acknowledge of the serviced source |
| repeat_byte | output | 1 | Execute the byte at PC again without advancing |
| status | output | 8 | Bit 0 master enable, bit 7 halted |

## Verification
The bench builds the block with its defaults:
- five sources, with the lowest index winning;
- vectors starting at 0x40 with a stride of 8;
- a 4-cycle wake window.

These values let the bench reach the last source's vector, 0x60. They also let it count the full stall window against `run`. The pending-request model in the bench clears a bit only when that bit is acknowledged. Raising several requests at once therefore shows whether untouched requests survive and come out later in priority order.

// File: rtl/ihs_pkg.sv
package ihs_pkg;
   localparam int ST_IME_BIT  = 0;
   localparam int ST_HALT_BIT = 7;

   typedef enum logic [1:0] {
      ACT_NONE    = 2'd0,
      ACT_SERVICE = 2'd1,
      ACT_REPEAT  = 2'd2,
      ACT_HALT    = 2'd3
   } act_e;
endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
   parameter int N        = 5,
   parameter int IW       = 3,
   parameter bit LOW_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  grant
);
   generate
      if (LOW_WINS) begin : g_low
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end else begin : g_high
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end
   endgenerate

   always_comb grant = found ? (N'(1) << idx) : '0;

   // R4
   grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> ($onehot(grant) && ((grant & req) == grant)));
endmodule

// File: rtl/intr_ime_ctrl.sv
module intr_ime_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic set_req,
   input  logic clr_req,
   input  logic svc,
   output logic ime,
   output logic allow
);
   always_ff @(posedge clk) begin
      if (!rst_n)                 ime <= 1'b0;
      else if (svc)               ime <= 1'b0;
      else if (upd && clr_req)    ime <= 1'b0;
      else if (upd && set_req)    ime <= 1'b1;
   end

   always_comb allow = ime && !(upd && (set_req || clr_req));

   // R5
   ei_sets_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && set_req && !clr_req && !svc) |=> ime);
   // R6
   di_clears_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && clr_req) |=> !ime);
endmodule

// File: rtl/intr_wake_timer.sv
module intr_wake_timer #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);
   generate
      if (CYC == 0) begin : g_none
         always_comb begin
            busy = 1'b0;
            last = start;
         end
      end else begin : g_cnt
         localparam int CW = $clog2(CYC + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (start)      cnt <= CW'(CYC);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         always_comb begin
            busy = (cnt != '0);
            last = (cnt == CW'(1));
         end
         // R9
         start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> !busy);
      end
   endgenerate
endmodule

// File: rtl/intr_halt_ctrl.sv
module intr_halt_ctrl #(
   parameter int N_SRC    = 5,
   parameter int VEC_W    = 16,
   parameter int VEC_BASE = 'h40,
   parameter int VEC_STEP = 8,
   parameter int WAKE_CYC = 4,
   parameter bit LOW_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary,
   input  logic             op_ei,
   input  logic             op_di,
   input  logic             op_halt,
   input  logic             op_reti,
   input  logic [N_SRC-1:0] req,
   output logic             run,
   output logic             take_irq,
   output logic [VEC_W-1:0] irq_vec,
   output logic [N_SRC-1:0] irq_ack,
   output logic             repeat_byte,
   output logic [7:0]       status
);
   import ihs_pkg::*;

   localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   generate
      if (N_SRC < 1 || N_SRC > 16) begin : g_bad_n
         $error("N_SRC out of range");
      end
      if (VEC_W < 8 || VEC_W > 32) begin : g_bad_w
         $error("VEC_W out of range");
      end
      if (WAKE_CYC < 0) begin : g_bad_wake
         $error("WAKE_CYC negative");
      end
   endgenerate

   logic          halted_q;
   logic          ime_w, allow_w;
   logic          found_w;
   logic [IW-1:0] idx_w;
   logic [N_SRC-1:0] grant_w;
   logic          wake_busy, wake_last;
   logic          act_bd, wake_start, chk, bug, enter, svc;
   act_e          act_n, act_q;
   logic [VEC_W-1:0] vec_n;

   always_comb begin
      act_bd     = boundary && run;
      wake_start = halted_q && (|req);
      chk        = act_bd || wake_last;
      bug        = act_bd && op_halt && !ime_w && (|req);
      enter      = act_bd && op_halt && !bug;
      svc        = chk && allow_w && found_w && !(act_bd && op_halt);
      vec_n      = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(idx_w);
      if (svc)        act_n = ACT_SERVICE;
      else if (bug)   act_n = ACT_REPEAT;
      else if (enter) act_n = ACT_HALT;
      else            act_n = ACT_NONE;
   end

   intr_prio_pick #(.N(N_SRC), .IW(IW), .LOW_WINS(LOW_WINS)) u_pick (
      .clk(clk), .rst_n(rst_n), .req(req),
      .found(found_w), .idx(idx_w), .grant(grant_w)
   );

   intr_ime_ctrl u_ime (
      .clk(clk), .rst_n(rst_n), .upd(act_bd),
      .set_req(op_ei || op_reti), .clr_req(op_di), .svc(svc),
      .ime(ime_w), .allow(allow_w)
   );

   intr_wake_timer #(.CYC(WAKE_CYC)) u_wake (
      .clk(clk), .rst_n(rst_n), .start(wake_start),
      .busy(wake_busy), .last(wake_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         act_q    <= ACT_NONE;
         irq_vec  <= '0;
         irq_ack  <= '0;
      end else begin
         if (enter)           halted_q <= 1'b1;
         else if (wake_start) halted_q <= 1'b0;
         act_q   <= act_n;
         irq_vec <= svc ? vec_n : '0;
         irq_ack <= svc ? grant_w : '0;
      end
   end

   always_comb begin
      run         = !halted_q && !wake_busy;
      take_irq    = (act_q == ACT_SERVICE);
      repeat_byte = (act_q == ACT_REPEAT);
      status      = '0;
      status[ST_IME_BIT]  = ime_w;
      status[ST_HALT_BIT] = halted_q;
   end

   // R3
   svc_clears_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> !status[ST_IME_BIT]);
   // R2
   no_svc_without_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> $past(ime_w));
   // R4
   ack_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> ($onehot(irq_ack) && ((irq_ack & $past(req)) == irq_ack)));
   // R8
   halt_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_HALT_BIT] |-> !run);
   // R11
   bug_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      repeat_byte |-> (!status[ST_HALT_BIT] && run));
   // R9
   wake_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(status[ST_HALT_BIT]) && (WAKE_CYC > 0)) |-> !run);
endmodule

// File: tb/intr_halt_ctrl_tb.sv
`timescale 1ns/1ps
module intr_halt_ctrl_tb;
   localparam int K_NONE = 0;
   localparam int K_EI   = 1;
   localparam int K_DI   = 2;
   localparam int K_HALT = 3;
   localparam int K_RETI = 4;

   typedef struct { logic [15:0] v; logic [4:0] a; } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic boundary = 1'b0, op_ei = 1'b0, op_di = 1'b0, op_halt = 1'b0, op_reti = 1'b0;
   logic [4:0] req_r = '0;
   logic run, take_irq, repeat_byte;
   logic [15:0] irq_vec;
   logic [4:0]  irq_ack;
   logic [7:0]  status;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   intr_halt_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .op_ei(op_ei), .op_di(op_di),
      .op_halt(op_halt), .op_reti(op_reti), .req(req_r), .run(run),
      .take_irq(take_irq), .irq_vec(irq_vec), .irq_ack(irq_ack),
      .repeat_byte(repeat_byte), .status(status)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   task automatic expect_svc(input logic [15:0] v, input logic [4:0] a);
      exp_t e;
      e.v = v;
      e.a = a;
      exp_q.push_back(e);
   endtask

   // monitor: compares every service strobe with the scoreboard
   task automatic tick();
      @(negedge clk);
      if (take_irq) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected service", int'(irq_vec), 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(irq_vec == e.v, "R4 vector", int'(irq_vec), int'(e.v));
            check(irq_ack == e.a, "R4 acknowledge", int'(irq_ack), int'(e.a));
         end
         req_r = req_r & ~irq_ack;
      end
   endtask

   task automatic instr(input int kind);
      boundary = 1'b1;
      op_ei   = (kind == K_EI);
      op_di   = (kind == K_DI);
      op_halt = (kind == K_HALT);
      op_reti = (kind == K_RETI);
      tick();
      boundary = 1'b0;
      op_ei = 1'b0; op_di = 1'b0; op_halt = 1'b0; op_reti = 1'b0;
   endtask

   initial begin
      int low;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1
      check(status == 8'h00, "R1 status after reset", status, 8'h00);
      check(run == 1'b1, "R1 run after reset", run, 1);

      // R2: pending with enable clear
      req_r = 5'b00100;
      instr(K_NONE);
      instr(K_NONE);
      check(exp_q.size() == 0 && req_r == 5'b00100, "R2 request untouched", req_r, 5'b00100);

      // R5: deferral of enable
      instr(K_EI);
      check(status == 8'h01, "R5 enable set, no service yet", status, 8'h01);
      check(req_r == 5'b00100, "R5 request still pending", req_r, 5'b00100);
      expect_svc(16'h0050, 5'b00100);
      instr(K_NONE);
      check(exp_q.size() == 0, "R5 service after one instruction", exp_q.size(), 0);
      // R3
      check(status == 8'h00, "R3 enable cleared by service", status, 8'h00);

      // R4: priority order
      req_r = 5'b11010;
      instr(K_EI);
      expect_svc(16'h0048, 5'b00010);
      instr(K_NONE);
      check(req_r == 5'b11000, "R4 others remain pending", req_r, 5'b11000);
      instr(K_EI);
      expect_svc(16'h0058, 5'b01000);
      instr(K_NONE);
      instr(K_EI);
      expect_svc(16'h0060, 5'b10000);
      instr(K_NONE);
      check(req_r == 5'b00000 && exp_q.size() == 0, "R4 last source serviced", req_r, 0);

      // R6: disable right after enable
      req_r = 5'b00001;
      instr(K_EI);
      instr(K_DI);
      check(status == 8'h00, "R6 disable clears enable", status, 8'h00);
      instr(K_NONE);
      check(req_r == 5'b00001, "R6 no service after disable", req_r, 5'b00001);

      // R7: return-from-interrupt defers like enable
      instr(K_RETI);
      check(status == 8'h01 && req_r == 5'b00001, "R7 enable set, deferred", status, 8'h01);
      expect_svc(16'h0040, 5'b00001);
      instr(K_NONE);
      check(exp_q.size() == 0 && req_r == 5'b00000, "R7 service after one instruction", req_r, 0);

      // R8: halt with nothing pending
      instr(K_HALT);
      check(status == 8'h80, "R8 halted status", status, 8'h80);
      check(run == 1'b0, "R8 run low while halted", run, 0);
      for (int i = 0; i < 5; i++) instr(K_EI);
      check(status == 8'h80, "R8 boundaries ignored while halted", status, 8'h80);

      // R9: wake with enable clear
      req_r = 5'b00100;
      low = 0;
      for (int i = 0; i < 12; i++) begin
         tick();
         if (run) break;
         low++;
      end
      check(low == 4, "R9 wake stall cycles", low, 4);
      check(status == 8'h00, "R9 halt ended without enable", status, 8'h00);
      check(req_r == 5'b00100, "R9 no service while disabled", req_r, 5'b00100);
      req_r = '0;

      // R10: wake with enable set
      instr(K_EI);
      instr(K_HALT);
      check(status == 8'h81, "R10 halted with enable", status, 8'h81);
      req_r = 5'b01000;
      expect_svc(16'h0058, 5'b01000);
      low = 0;
      for (int i = 0; i < 12; i++) begin
         tick();
         if (run) break;
         low++;
      end
      check(low == 4, "R10 wake stall cycles", low, 4);
      check(exp_q.size() == 0 && status == 8'h00, "R10 serviced at wake end", status, 8'h00);

      // R11: halt quirk
      req_r = 5'b00010;
      instr(K_HALT);
      check(repeat_byte == 1'b1, "R11 repeat pulse", repeat_byte, 1);
      check(status == 8'h00 && run == 1'b1, "R11 halt not taken", status, 8'h00);
      req_r = '0;
      tick();
      check(repeat_byte == 1'b0, "R11 repeat is one cycle", repeat_byte, 0);
      check(exp_q.size() == 0, "R4 all expected services delivered", exp_q.size(), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule